// File: doc/BRIEF.md
# Retire Control Unit for a Reorder Buffer

This block tracks instructions that have been dispatched but not yet retired. It holds a circular buffer of slots. Each instruction reserves a run of consecutive slots, one per micro-op. The reservation returns a token ID, which is the slot where the run starts. The token remembers the instruction index, how many slots it took and whether it has finished executing. When the execution units report a token as done, its executed flag is set.

On every cycle that the tick input is high, the unit retires executed tokens, oldest first. It stops at the first token that has not executed, or when it reaches the per-cycle retire limit. A retire limit of zero removes the cap. The slots of retired tokens go back to the free pool. One cycle later, each retired instruction index appears on its own lane of the retire outputs, so that downstream logic can release the rename mappings held by that instruction.

A dispatcher uses the block as follows. It presents an instruction index and a micro-op count, and reads `rsv_avail` and `rsv_token` in the same cycle. It keeps the token ID for the later completion report, and it reads `full` and `empty` to decide whether to stall or drain.

Top module: `rcu_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rsv_token` is 0 and every `ret_valid` lane is 0.
- R2: A request's slot count is the micro-op count capped at NUM_SLOTS, and a count of zero takes one slot. `rsv_avail` is 1 exactly when this capped count is no greater than the number of free slots.
- R3: An accepted reservation (`rsv_valid` and `rsv_avail` both 1) returns the current start slot on `rsv_token` in the same cycle. The next token ID is that slot plus the capped count, modulo NUM_SLOTS.
- R4: A reservation request made while `rsv_avail` is 0 is ignored: the token ID, the free slots and the retire order do not change.
- R5: `full` is 1 exactly when no slot is free. `empty` is 1 exactly when all NUM_SLOTS slots are free.
- R6: An execute report sets the executed flag of the live token that starts at `exec_token`. A report that names a slot where no live token starts has no effect.
- R7: Retirement happens only in a cycle with `tick` high. It takes tokens in the order they were reserved, and it stops at the first token that has not executed, even if younger tokens have executed.
- R8: One tick retires at most MAX_RETIRE tokens. With MAX_RETIRE = 0, a single tick may retire every live token.
- R9: Retirements appear in the cycle after the tick. Lanes 0 upward of `ret_valid` are set with no gaps, and lane k carries, in `ret_index[k*IDX_W +: IDX_W]`, the index of the k-th oldest retired token. The slots of the retired tokens are free from that cycle on.
- R10: The oldest token retires on a tick even when its execute report arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_index | input | IDX_W | Instruction index of the request |
| rsv_uops | input | UOP_W | Micro-op count of the request |
| rsv_token | output | PTR_W | Start slot the next reservation receives |
| rsv_avail | output | 1 | Enough free slots for the capped request |
| exec_valid | input | 1 | Execute report |
| exec_token | input | PTR_W | Token ID that finished executing |
| tick | input | 1 | Cycle event that allows retirement |
| ret_valid | output | LANES | Retire lane valid flags |
| ret_index | output | LANES*IDX_W | Retired instruction indices, lane 0 in the low bits |
| full | output | 1 | No free slot |
| empty | output | 1 | All slots free |

## Verification
Some properties are checked by assertions on every cycle:
- the free count stays within the buffer;
- the start pointer holds still whenever no reservation is taken;
- every retiring lane points at the start slot of a live token;
- an executed flag exists only on a live token;
- retire lanes are set with no gaps and only after a tick;
- `full` and `empty` are never high together.

Other behaviours need scenarios with known values, driven by the bench:
- the retire order and the point where retirement stops;
- the per-tick limit;
- the capping of oversized requests and the wrap-around of token IDs;
- an execute report and a retirement of the same token in one cycle.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  // Number of retire lanes: the per-cycle limit, or the whole buffer when the limit is zero or too large.
  function automatic int unsigned retire_lanes(input int unsigned slots, input int unsigned limit);
    return (limit == 0 || limit > slots) ? slots : limit;
  endfunction

  // Width of a slot pointer. A buffer with one slot still gets a one-bit pointer.
  function automatic int unsigned ptr_width(input int unsigned slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/rcu_alloc.sv
module rcu_alloc #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned UOP_W     = 5,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsv_valid,
  input  logic [UOP_W-1:0] rsv_uops,
  input  logic [CNT_W-1:0] freed_slots,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] free_cnt,
  output logic [CNT_W-1:0] req_slots,
  output logic             avail,
  output logic             accept
);

  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] free_q, free_d;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(p) + (CNT_W+1)'(n);
    if (s >= (CNT_W+1)'(NUM_SLOTS)) s = s - (CNT_W+1)'(NUM_SLOTS);
    return PTR_W'(s);
  endfunction

  // Capped slot request: zero micro-ops still take one slot.
  always_comb begin
    if (rsv_uops == '0)                   req_slots = CNT_W'(1);
    else if (32'(rsv_uops) > NUM_SLOTS)   req_slots = CNT_W'(NUM_SLOTS);
    else                                  req_slots = CNT_W'(rsv_uops);
  end

  assign avail  = (free_q >= req_slots);
  assign accept = rsv_valid && avail;

  always_comb begin
    tail_d = tail_q;
    free_d = free_q + freed_slots;
    if (accept) begin
      tail_d = wrap_add(tail_q, req_slots);
      free_d = free_d - req_slots;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      free_q <= CNT_W'(NUM_SLOTS);
    end else begin
      tail_q <= tail_d;
      free_q <= free_d;
    end
  end

  assign tail     = tail_q;
  assign free_cnt = free_q;

  // R5
  free_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_W'(NUM_SLOTS));

  // R4
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tail_q));

endmodule

// File: rtl/rcu_retire_sel.sv
module rcu_retire_sel #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned LANES     = 2,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             tick,
  input  logic [PTR_W-1:0] head,
  input  logic [CNT_W-1:0] used,
  input  logic             exec_eff [NUM_SLOTS],
  input  logic [CNT_W-1:0] nslots   [NUM_SLOTS],
  output logic             lane_go  [LANES],
  output logic [PTR_W-1:0] lane_ptr [LANES],
  output logic [CNT_W-1:0] freed,
  output logic [PTR_W-1:0] head_next
);

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(p) + (CNT_W+1)'(n);
    if (s >= (CNT_W+1)'(NUM_SLOTS)) s = s - (CNT_W+1)'(NUM_SLOTS);
    return PTR_W'(s);
  endfunction

  // Walk the buffer from the oldest token. Each lane may retire only if the lane before it did.
  always_comb begin
    logic [PTR_W-1:0] ptr;
    logic [CNT_W:0]   acc;
    logic             ok;
    ptr = head;
    acc = '0;
    ok  = tick;
    for (int k = 0; k < int'(LANES); k++) begin
      lane_ptr[k] = ptr;
      lane_go[k]  = ok && (acc < (CNT_W+1)'(used)) && exec_eff[ptr];
      if (lane_go[k]) begin
        acc = acc + (CNT_W+1)'(nslots[ptr]);
        ptr = wrap_add(ptr, nslots[ptr]);
      end
      ok = lane_go[k];
    end
    freed     = CNT_W'(acc);
    head_next = ptr;
  end

endmodule

// File: rtl/rcu_token_store.sv
module rcu_token_store #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned LANES     = 2,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [CNT_W-1:0] wr_slots,
  input  logic             exec_valid,
  input  logic [PTR_W-1:0] exec_token,
  input  logic             lane_go  [LANES],
  input  logic [PTR_W-1:0] lane_ptr [LANES],
  output logic             exec_eff [NUM_SLOTS],
  output logic [CNT_W-1:0] nslots   [NUM_SLOTS],
  output logic [IDX_W-1:0] index    [NUM_SLOTS]
);

  // A token's fields live in its start slot only.
  logic             start_q [NUM_SLOTS];
  logic             start_d [NUM_SLOTS];
  logic             done_q  [NUM_SLOTS];
  logic             done_d  [NUM_SLOTS];
  logic [CNT_W-1:0] nsl_q   [NUM_SLOTS];
  logic [IDX_W-1:0] idx_q   [NUM_SLOTS];
  logic             hit     [NUM_SLOTS];

  // Decode the execute report per slot. A slot number past the buffer matches nothing.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s]      = exec_valid && (32'(exec_token) == s) && start_q[s];
    assign exec_eff[s] = done_q[s] || hit[s];
    assign nslots[s]   = nsl_q[s];
    assign index[s]    = idx_q[s];
  end

  // Apply the execute report first, then clear retired tokens, then write the new reservation.
  always_comb begin
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      start_d[s] = start_q[s];
      done_d[s]  = exec_eff[s];
    end
    for (int k = 0; k < int'(LANES); k++) begin
      if (lane_go[k]) begin
        start_d[lane_ptr[k]] = 1'b0;
        done_d[lane_ptr[k]]  = 1'b0;
      end
    end
    if (wr_en) begin
      start_d[wr_ptr] = 1'b1;
      done_d[wr_ptr]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) begin
        start_q[s] <= 1'b0;
        done_q[s]  <= 1'b0;
      end
    end else begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) begin
        start_q[s] <= start_d[s];
        done_q[s]  <= done_d[s];
      end
    end
  end

  // Payload registers carry no reset. They are read only where start_q is set.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      nsl_q[wr_ptr] <= wr_slots;
      idx_q[wr_ptr] <= wr_index;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R7
    lane_on_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_go[k] |-> start_q[lane_ptr[k]]);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    // R6
    done_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q[s] |-> start_q[s]);
  end

endmodule

// File: rtl/rcu_top.sv
module rcu_top
  import rcu_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 12,
  parameter int unsigned MAX_RETIRE = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned UOP_W      = 5,
  localparam int unsigned LANES     = retire_lanes(NUM_SLOTS, MAX_RETIRE),
  localparam int unsigned PTR_W     = ptr_width(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rsv_valid,
  input  logic [IDX_W-1:0]       rsv_index,
  input  logic [UOP_W-1:0]       rsv_uops,
  output logic [PTR_W-1:0]       rsv_token,
  output logic                   rsv_avail,
  input  logic                   exec_valid,
  input  logic [PTR_W-1:0]       exec_token,
  input  logic                   tick,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*IDX_W-1:0] ret_index,
  output logic                   full,
  output logic                   empty
);

  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

  initial begin
    if (NUM_SLOTS < 1) $error("rcu_top: NUM_SLOTS must be at least 1");
  end

  logic [PTR_W-1:0] tail, head_q, head_d, head_next;
  logic [CNT_W-1:0] free_cnt, req_slots, freed, used;
  logic             accept;
  logic             exec_eff [NUM_SLOTS];
  logic [CNT_W-1:0] nslots   [NUM_SLOTS];
  logic [IDX_W-1:0] index    [NUM_SLOTS];
  logic             lane_go  [LANES];
  logic [PTR_W-1:0] lane_ptr [LANES];
  logic [LANES-1:0]       rv_q, rv_d;
  logic [LANES*IDX_W-1:0] ri_q, ri_d;

  rcu_alloc #(.NUM_SLOTS(NUM_SLOTS), .UOP_W(UOP_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_alloc (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsv_valid   (rsv_valid),
    .rsv_uops    (rsv_uops),
    .freed_slots (freed),
    .tail        (tail),
    .free_cnt    (free_cnt),
    .req_slots   (req_slots),
    .avail       (rsv_avail),
    .accept      (accept)
  );

  assign used = CNT_W'(NUM_SLOTS) - free_cnt;

  rcu_retire_sel #(.NUM_SLOTS(NUM_SLOTS), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_sel (
    .tick      (tick),
    .head      (head_q),
    .used      (used),
    .exec_eff  (exec_eff),
    .nslots    (nslots),
    .lane_go   (lane_go),
    .lane_ptr  (lane_ptr),
    .freed     (freed),
    .head_next (head_next)
  );

  rcu_token_store #(.NUM_SLOTS(NUM_SLOTS), .LANES(LANES), .IDX_W(IDX_W),
                    .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept),
    .wr_ptr     (tail),
    .wr_index   (rsv_index),
    .wr_slots   (req_slots),
    .exec_valid (exec_valid),
    .exec_token (exec_token),
    .lane_go    (lane_go),
    .lane_ptr   (lane_ptr),
    .exec_eff   (exec_eff),
    .nslots     (nslots),
    .index      (index)
  );

  // Build the next retire event from the lanes that fire in this cycle.
  always_comb begin
    head_d = head_next;
    for (int k = 0; k < int'(LANES); k++) begin
      rv_d[k]                = lane_go[k];
      ri_d[k*IDX_W +: IDX_W] = lane_go[k] ? index[lane_ptr[k]] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      rv_q   <= '0;
      ri_q   <= '0;
    end else begin
      head_q <= head_d;
      rv_q   <= rv_d;
      ri_q   <= ri_d;
    end
  end

  assign rsv_token = tail;
  assign ret_valid = rv_q;
  assign ret_index = ri_q;
  assign full      = (free_cnt == '0);
  assign empty     = (free_cnt == CNT_W'(NUM_SLOTS));

  // R5
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R9
  lanes_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid & (ret_valid + 1'b1)) == '0));

  // R7
  retire_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (ret_valid == '0));

endmodule

// File: tb/tb_rcu_top.sv
`timescale 1ns/1ps
module tb_rcu_top;

  localparam int N     = 12;
  localparam int MR    = 2;
  localparam int IDX_W = 8;
  localparam int UOP_W = 5;
  localparam int LANES = (MR == 0 || MR > N) ? N : MR;
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic                   clk, rst_n;
  logic                   rsv_valid, exec_valid, tick;
  logic [IDX_W-1:0]       rsv_index;
  logic [UOP_W-1:0]       rsv_uops;
  logic [PTR_W-1:0]       rsv_token, exec_token;
  logic                   rsv_avail, full, empty;
  logic [LANES-1:0]       ret_valid;
  logic [LANES*IDX_W-1:0] ret_index;

  rcu_top #(.NUM_SLOTS(N), .MAX_RETIRE(MR), .IDX_W(IDX_W), .UOP_W(UOP_W)) dut (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_index(rsv_index),
    .rsv_uops(rsv_uops), .rsv_token(rsv_token), .rsv_avail(rsv_avail),
    .exec_valid(exec_valid), .exec_token(exec_token), .tick(tick),
    .ret_valid(ret_valid), .ret_index(ret_index), .full(full), .empty(empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // Reference model: a queue of live tokens, with the oldest at m_head.
  int m_start [N];
  int m_n     [N];
  int m_idx   [N];
  bit m_exec  [N];
  int m_head, m_cnt, m_free, m_tail;
  int exp_cnt;
  int exp_idx [LANES];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cap(input int u);
    return (u == 0) ? 1 : ((u > N) ? N : u);
  endfunction

  task automatic model_reset();
    m_head = 0; m_cnt = 0; m_free = N; m_tail = 0; exp_cnt = 0;
  endtask

  // One cycle: check the registered retire event, drive the inputs, check the combinational outputs, update the model.
  task automatic step(input bit rv, input int ridx, input int ru, input bit ev, input int etok, input bit tk);
    int pre_free;
    for (int k = 0; k < LANES; k++) begin
      chk(ret_valid[k] == (k < exp_cnt), "R9", $sformatf("ret_valid lane %0d", k), ret_valid[k], k < exp_cnt);
      if (k < exp_cnt)
        chk(int'(ret_index[k*IDX_W +: IDX_W]) == exp_idx[k], "R7", $sformatf("ret_index lane %0d", k),
            ret_index[k*IDX_W +: IDX_W], exp_idx[k]);
    end
    rsv_valid  = rv;
    rsv_index  = IDX_W'(ridx);
    rsv_uops   = UOP_W'(ru);
    exec_valid = ev;
    exec_token = PTR_W'(etok);
    tick       = tk;
    #1;
    chk(full == (m_free == 0), "R5", "full", full, m_free == 0);
    chk(empty == (m_free == N), "R5", "empty", empty, m_free == N);
    chk(rsv_avail == (cap(ru) <= m_free), "R2", "rsv_avail", rsv_avail, cap(ru) <= m_free);
    chk(int'(rsv_token) == m_tail, "R3", "rsv_token", rsv_token, m_tail);
    pre_free = m_free;
    // R6 and R10: the execute report takes effect before retirement.
    if (ev)
      for (int k = 0; k < m_cnt; k++)
        if (m_start[(m_head + k) % N] == etok) m_exec[(m_head + k) % N] = 1'b1;
    exp_cnt = 0;
    if (tk)
      while (m_cnt > 0 && exp_cnt < LANES && m_exec[m_head]) begin
        exp_idx[exp_cnt] = m_idx[m_head];
        exp_cnt++;
        m_free += m_n[m_head];
        m_head = (m_head + 1) % N;
        m_cnt--;
      end
    // R4: a request without enough free slots leaves the model unchanged.
    if (rv && cap(ru) <= pre_free) begin
      int t;
      t = (m_head + m_cnt) % N;
      m_start[t] = m_tail;
      m_n[t]     = cap(ru);
      m_idx[t]   = ridx % (1 << IDX_W);
      m_exec[t]  = 1'b0;
      m_cnt++;
      m_free -= cap(ru);
      m_tail = (m_tail + cap(ru)) % N;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input bit tk);
    step(0, 0, 1, 0, 0, tk);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rsv_valid = 0; rsv_index = '0; rsv_uops = '0; exec_valid = 0; exec_token = '0; tick = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: the state right after reset.
    #1;
    chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
    chk(full == 1'b0, "R1", "full after reset", full, 0);
    chk(rsv_token == '0, "R1", "token after reset", rsv_token, 0);
    chk(ret_valid == '0, "R1", "ret_valid after reset", ret_valid, 0);

    // R2/R3: zero micro-ops takes one slot, then three slots.
    step(1, 11, 0, 0, 0, 0);     // token 0, 1 slot
    step(1, 12, 3, 0, 0, 0);     // token 1, 3 slots
    // R4: oversized request (capped to 12) with 8 slots free is ignored.
    step(1, 99, 30, 0, 0, 0);
    // R7: the younger token has executed, the older has not, so no retirement.
    step(0, 0, 1, 1, 1, 1);
    idle(0);
    // R10: the head executes in the same cycle as the tick, and both tokens retire.
    step(0, 0, 1, 1, 0, 1);
    idle(0);
    // R2: a capped request fits in an empty buffer and fills it (R5).
    step(1, 20, 31, 0, 0, 0);
    idle(0);
    // R6: a report naming a slot with no live token start is ignored.
    step(0, 0, 1, 1, 7, 1);
    idle(1);
    step(0, 0, 1, 1, 4, 1);
    idle(0);
    // R8: three executed tokens take two ticks to retire.
    step(1, 31, 1, 0, 0, 0);
    step(1, 32, 1, 0, 0, 0);
    step(1, 33, 1, 0, 0, 0);
    step(0, 0, 1, 1, 4, 0);
    step(0, 0, 1, 1, 5, 0);
    step(0, 0, 1, 1, 6, 0);
    step(0, 0, 1, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    idle(0);

    // Random traffic, checked against the model on every cycle (R2-R10).
    for (int i = 0; i < 4000; i++) begin
      bit rv, ev, tk;
      int ru, et;
      rv = ($urandom_range(0, 99) < 55);
      ru = ($urandom_range(0, 9) == 0) ? $urandom_range(13, 31) : $urandom_range(0, 5);
      ev = ($urandom_range(0, 99) < 70);
      if (m_cnt > 0 && $urandom_range(0, 9) < 8)
        et = m_start[(m_head + $urandom_range(0, m_cnt - 1)) % N];
      else
        et = $urandom_range(0, (1 << PTR_W) - 1);
      tk = ($urandom_range(0, 99) < 60);
      step(rv, $urandom_range(0, 255), ru, ev, et, tk);
    end
    idle(0);
    idle(0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule